// File: doc/BRIEF.md
# Security-Aware Cache Maintenance Engine

This block is the maintenance controller of a small set-associative cache tag array. Each line carries a valid bit, a dirty bit, a lock bit, an origin bit that marks the line as belonging to the non-secure address space, an ASID and an address tag. The controller takes one command at a time. A command is invalidate, clean, or clean-and-invalidate. Its target is the whole array, one set/way position, or one virtual address. The requester's security state and current ASID arrive with the command.

The requester's security state only changes which lines a command selects. The same rules apply to all three operations. Lock handling does not depend on security: when lockdown aborts are enabled, a selected locked line aborts the command in either state. Cleaning a dirty line raises a writeback request and waits for its acknowledge. Data storage and the writeback transfer itself live outside the block. The tag array sits inside the block, with a fill port and a read port so that the surrounding cache can load and inspect lines.

Top module: `cache_maint_engine`

## Requirements
- R1: An all-lines command from the secure state (`cmd_sec_i`=1, `cmd_scope_i`=0) reaches every valid line whatever its origin bit. It visits one line per cycle, starting at set 0, way 0, with the way advancing first. `done_o` rises in the (N_SETS*N_WAYS+1)-th cycle after the accepting edge when no writeback occurs.
- R2: An all-lines command from the non-secure state (`cmd_sec_i`=0) reaches only lines whose origin bit `ns` is 1. Lines with `ns`=0 keep their state.
- R3: A set/way command (`cmd_scope_i`=1) from the non-secure state acts on the chosen line only if its `ns` is 1. Otherwise it completes with `err_o`=0 and leaves the line unchanged.
- R4: A set/way command from the secure state acts on the chosen line regardless of `ns`.
- R5: An address command (`cmd_scope_i`=2) checks every way of the set given by VA bits [9:6]. It acts on a line only when the line's tag equals VA bits [31:10], its ASID equals `cmd_asid_i`, and its `ns` equals `cmd_ns_i`. This holds in either security state.
- R6: Clean (`cmd_op_i`=1) on a selected dirty line holds `wb_req_o` with a constant `wb_set_o`/`wb_way_o` until `wb_ack_i`. It then clears the dirty bit and keeps the line valid. A clean line produces no request.
- R7: Clean-and-invalidate (`cmd_op_i`=2) on a selected dirty line issues the writeback and then clears both dirty and valid. Invalidate (`cmd_op_i`=0) clears valid and dirty without a writeback.
- R8: With `lock_abort_en_i`=1, a selected locked line ends the command in either security state. `done_o` is raised with `err_o`=1, and no writeback is issued. That line and every line after it in the walk stay unchanged, while lines already visited keep their updates.
- R9: A locked line aborts only if the command selects it. With `lock_abort_en_i`=0, locked lines are maintained like any other line.
- R10: While `busy_o` is high, `cmd_rdy_o` is low and any command presented has no effect.
- R11: `done_o` is a single-cycle pulse, and `err_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_vld_i | input | 1 | Command valid |
| cmd_rdy_o | output | 1 | Command accepted when high with valid |
| cmd_op_i | input | 2 | 0 invalidate, 1 clean, 2 clean-and-invalidate |
| cmd_scope_i | input | 2 | 0 all lines, 1 set/way, 2 virtual address |
| cmd_sec_i | input | 1 | Requester is in secure state |
| cmd_asid_i | input | ASID_W | Requester's current ASID |
| cmd_ns_i | input | 1 | Address space of an address command |
| cmd_va_i | input | VA_W | Virtual address for address commands |
| cmd_set_i | input | SET_W | Set for set/way commands |
| cmd_way_i | input | WAY_W | Way for set/way commands |
| lock_abort_en_i | input | 1 | Abort on selected locked lines |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Lock abort status, valid with done_o |
| wb_req_o | output | 1 | Writeback request |
| wb_ack_i | input | 1 | Writeback acknowledge |
| wb_set_o | output | SET_W | Set of line to write back |
| wb_way_o | output | WAY_W | Way of line to write back |
| fill_we_i | input | 1 | Tag array fill write |
| fill_set_i | input | SET_W | Fill set |
| fill_way_i | input | WAY_W | Fill way |
| fill_valid_i | input | 1 | Fill valid bit |
| fill_dirty_i | input | 1 | Fill dirty bit |
| fill_lock_i | input | 1 | Fill lock bit |
| fill_ns_i | input | 1 | Fill non-secure origin bit |
| fill_asid_i | input | ASID_W | Fill ASID |
| fill_tag_i | input | TAG_W | Fill address tag |
| rd_set_i | input | SET_W | Read port set |
| rd_way_i | input | WAY_W | Read port way |
| rd_valid_o | output | 1 | Read valid bit |
| rd_dirty_o | output | 1 | Read dirty bit |
| rd_lock_o | output | 1 | Read lock bit |
| rd_ns_o | output | 1 | Read origin bit |

## Verification
The bench places lines with `ns`=0 next to lines with `ns`=1 and sends all-lines and set/way commands from both states. A design that ignored the security state would wipe secure lines on a non-secure request. A design that applied the filter to the secure state as well would leave secure lines stale. In one set, the address test loads four ways that each match on only some of tag, ASID and origin, so a design that left out any one of the three comparisons would invalidate an extra way. The abort tests put a locked line midway through a secure walk and check both sides of it: a design that kept walking after the abort would clear later lines, and one that rolled back would restore earlier ones. They also place a locked line that the command does not select and check that no abort is raised. The writeback tests delay the acknowledge and check that the request and its coordinates stay fixed until it arrives and that the dirty and valid bits end up in the right state for clean and for clean-and-invalidate.

// File: rtl/cme_pkg.sv
package cme_pkg;
  localparam logic [1:0] OP_INV  = 2'd0;
  localparam logic [1:0] OP_CLN  = 2'd1;
  localparam logic [1:0] OP_CINV = 2'd2;

  localparam logic [1:0] SC_ALL = 2'd0;
  localparam logic [1:0] SC_SW  = 2'd1;
  localparam logic [1:0] SC_VA  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WB, ST_DONE} state_e;
endpackage

// File: rtl/cme_tag_array.sv
module cme_tag_array #(
  parameter int N_ENT  = 64,
  parameter int ENT_W  = 6,
  parameter int ASID_W = 8,
  parameter int TAG_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [ENT_W-1:0]  fill_idx_i,
  input  logic              fill_valid_i,
  input  logic              fill_dirty_i,
  input  logic              fill_lock_i,
  input  logic              fill_ns_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              mw_en_i,
  input  logic [ENT_W-1:0]  mw_idx_i,
  input  logic              mw_clr_valid_i,
  input  logic              mw_clr_dirty_i,
  input  logic [ENT_W-1:0]  a_idx_i,
  output logic              a_valid_o,
  output logic              a_dirty_o,
  output logic              a_lock_o,
  output logic              a_ns_o,
  output logic [ASID_W-1:0] a_asid_o,
  output logic [TAG_W-1:0]  a_tag_o,
  input  logic [ENT_W-1:0]  b_idx_i,
  output logic              b_valid_o,
  output logic              b_dirty_o,
  output logic              b_lock_o,
  output logic              b_ns_o
);
  logic              valid_q [N_ENT];
  logic              dirty_q [N_ENT];
  logic              lock_q  [N_ENT];
  logic              ns_q    [N_ENT];
  logic [ASID_W-1:0] asid_q  [N_ENT];
  logic [TAG_W-1:0]  tag_q   [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) begin
        valid_q[e] <= 1'b0;
        dirty_q[e] <= 1'b0;
        lock_q[e]  <= 1'b0;
        ns_q[e]    <= 1'b0;
        asid_q[e]  <= '0;
        tag_q[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        // maintenance write wins over a fill to the same entry
        if (mw_en_i && mw_idx_i == ENT_W'(e)) begin
          if (mw_clr_valid_i) valid_q[e] <= 1'b0;
          if (mw_clr_dirty_i) dirty_q[e] <= 1'b0;
        end else if (fill_we_i && fill_idx_i == ENT_W'(e)) begin
          valid_q[e] <= fill_valid_i;
          dirty_q[e] <= fill_dirty_i;
          lock_q[e]  <= fill_lock_i;
          ns_q[e]    <= fill_ns_i;
          asid_q[e]  <= fill_asid_i;
          tag_q[e]   <= fill_tag_i;
        end
      end
    end
  end

  assign a_valid_o = valid_q[a_idx_i];
  assign a_dirty_o = dirty_q[a_idx_i];
  assign a_lock_o  = lock_q[a_idx_i];
  assign a_ns_o    = ns_q[a_idx_i];
  assign a_asid_o  = asid_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];

  assign b_valid_o = valid_q[b_idx_i];
  assign b_dirty_o = dirty_q[b_idx_i];
  assign b_lock_o  = lock_q[b_idx_i];
  assign b_ns_o    = ns_q[b_idx_i];
endmodule

// File: rtl/cme_select.sv
module cme_select
  import cme_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int TAG_W  = 22
) (
  input  logic              line_valid_i,
  input  logic              line_ns_i,
  input  logic [ASID_W-1:0] line_asid_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [1:0]        scope_i,
  input  logic              sec_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              ns_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o
);
  always_comb begin
    unique case (scope_i)
      SC_ALL, SC_SW: hit_o = line_valid_i && (sec_i || line_ns_i);
      SC_VA:         hit_o = line_valid_i && (line_tag_i == tag_i) &&
                             (line_asid_i == asid_i) && (line_ns_i == ns_i);
      default:       hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
#(
  parameter int N_SETS = 16,
  parameter int N_WAYS = 4,
  parameter int ASID_W = 8,
  parameter int VA_W   = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  output logic              cmd_rdy_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_scope_i,
  input  logic              cmd_sec_i,
  input  logic [ASID_W-1:0] cmd_asid_i,
  input  logic              cmd_ns_i,
  input  logic [VA_W-1:0]   cmd_va_i,
  input  logic [SET_W-1:0]  cmd_set_i,
  input  logic [WAY_W-1:0]  cmd_way_i,
  input  logic              lock_abort_en_i,
  input  logic              hit_i,
  input  logic              line_dirty_i,
  input  logic              line_lock_i,
  output logic [SET_W-1:0]  set_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [1:0]        scope_o,
  output logic              sec_o,
  output logic [ASID_W-1:0] asid_o,
  output logic              ns_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              abort_en_o,
  output logic              mw_en_o,
  output logic              mw_clr_valid_o,
  output logic              mw_clr_dirty_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_req_o,
  input  logic              wb_ack_i
);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(N_SETS - 1);
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(N_WAYS - 1);

  state_e            state_q, state_d;
  logic [1:0]        op_q, op_d, scope_q, scope_d;
  logic              sec_q, sec_d, ns_q, ns_d, en_q, en_d, err_q, err_d;
  logic [ASID_W-1:0] asid_q, asid_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [SET_W-1:0]  set_q, set_d, nxt_set;
  logic [WAY_W-1:0]  way_q, way_d, nxt_way;
  logic              last_line, do_clean, do_inv;

  assign do_clean = (op_q != OP_INV);
  assign do_inv   = (op_q != OP_CLN);

  always_comb begin
    if (way_q == WAY_MAX) begin
      nxt_way = '0;
      nxt_set = set_q + SET_W'(1);
    end else begin
      nxt_way = way_q + WAY_W'(1);
      nxt_set = set_q;
    end
    unique case (scope_q)
      SC_ALL:  last_line = (set_q == SET_MAX) && (way_q == WAY_MAX);
      SC_VA:   last_line = (way_q == WAY_MAX);
      default: last_line = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    op_d = op_q; scope_d = scope_q; sec_d = sec_q; ns_d = ns_q;
    en_d = en_q; err_d = err_q; asid_d = asid_q; tag_d = tag_q;
    set_d = set_q; way_d = way_q;
    mw_en_o = 1'b0; mw_clr_valid_o = 1'b0; mw_clr_dirty_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_vld_i) begin
          state_d = ST_SCAN;
          op_d    = cmd_op_i;
          scope_d = cmd_scope_i;
          sec_d   = cmd_sec_i;
          asid_d  = cmd_asid_i;
          ns_d    = cmd_ns_i;
          en_d    = lock_abort_en_i;
          err_d   = 1'b0;
          tag_d   = cmd_va_i[VA_W-1 -: TAG_W];
          unique case (cmd_scope_i)
            SC_ALL:  begin set_d = '0;                             way_d = '0;        end
            SC_VA:   begin set_d = cmd_va_i[OFF_W +: SET_W];       way_d = '0;        end
            default: begin set_d = cmd_set_i;                      way_d = cmd_way_i; end
          endcase
        end
      end
      ST_SCAN: begin
        if (hit_i && line_lock_i && en_q) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else if (hit_i && do_clean && line_dirty_i) begin
          state_d = ST_WB;
        end else begin
          if (hit_i && do_inv) begin
            mw_en_o        = 1'b1;
            mw_clr_valid_o = 1'b1;
            mw_clr_dirty_o = 1'b1;
          end
          if (last_line) state_d = ST_DONE;
          else begin set_d = nxt_set; way_d = nxt_way; end
        end
      end
      ST_WB: begin
        if (wb_ack_i) begin
          mw_en_o        = 1'b1;
          mw_clr_dirty_o = 1'b1;
          mw_clr_valid_o = do_inv;
          if (last_line) state_d = ST_DONE;
          else begin
            state_d = ST_SCAN;
            set_d   = nxt_set;
            way_d   = nxt_way;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q <= OP_INV; scope_q <= SC_ALL;
      sec_q <= 1'b0; ns_q <= 1'b0; en_q <= 1'b0; err_q <= 1'b0;
      asid_q <= '0; tag_q <= '0; set_q <= '0; way_q <= '0;
    end else begin
      state_q <= state_d;
      op_q <= op_d; scope_q <= scope_d;
      sec_q <= sec_d; ns_q <= ns_d; en_q <= en_d; err_q <= err_d;
      asid_q <= asid_d; tag_q <= tag_d; set_q <= set_d; way_q <= way_d;
    end
  end

  assign cmd_rdy_o  = (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = done_o && err_q;
  assign wb_req_o   = (state_q == ST_WB);
  assign set_o      = set_q;
  assign way_o      = way_q;
  assign scope_o    = scope_q;
  assign sec_o      = sec_q;
  assign asid_o     = asid_q;
  assign ns_o       = ns_q;
  assign tag_o      = tag_q;
  assign abort_en_o = en_q;
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
  parameter int N_SETS     = 16,
  parameter int N_WAYS     = 4,
  parameter int ASID_W     = 8,
  parameter int VA_W       = 32,
  parameter int LINE_BYTES = 64,
  localparam int SET_W = $clog2(N_SETS),
  localparam int WAY_W = $clog2(N_WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = VA_W - OFF_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  output logic              cmd_rdy_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_scope_i,
  input  logic              cmd_sec_i,
  input  logic [ASID_W-1:0] cmd_asid_i,
  input  logic              cmd_ns_i,
  input  logic [VA_W-1:0]   cmd_va_i,
  input  logic [SET_W-1:0]  cmd_set_i,
  input  logic [WAY_W-1:0]  cmd_way_i,
  input  logic              lock_abort_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  output logic [SET_W-1:0]  wb_set_o,
  output logic [WAY_W-1:0]  wb_way_o,
  input  logic              fill_we_i,
  input  logic [SET_W-1:0]  fill_set_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic              fill_valid_i,
  input  logic              fill_dirty_i,
  input  logic              fill_lock_i,
  input  logic              fill_ns_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic              rd_lock_o,
  output logic              rd_ns_o
);
  localparam int N_ENT = N_SETS * N_WAYS;
  localparam int ENT_W = SET_W + WAY_W;

  logic [SET_W-1:0]  cur_set;
  logic [WAY_W-1:0]  cur_way;
  logic [1:0]        scope_q;
  logic              sec_q, ns_q, abort_en_q, hit;
  logic [ASID_W-1:0] asid_q, cur_asid;
  logic [TAG_W-1:0]  tag_q, cur_tag;
  logic              cur_valid, cur_dirty, cur_lock, cur_ns;
  logic              mw_en, mw_clr_valid, mw_clr_dirty;

  cme_tag_array #(
    .N_ENT(N_ENT), .ENT_W(ENT_W), .ASID_W(ASID_W), .TAG_W(TAG_W)
  ) u_arr (
    .clk_i, .rst_ni,
    .fill_we_i, .fill_idx_i({fill_set_i, fill_way_i}),
    .fill_valid_i, .fill_dirty_i, .fill_lock_i, .fill_ns_i, .fill_asid_i, .fill_tag_i,
    .mw_en_i(mw_en), .mw_idx_i({cur_set, cur_way}),
    .mw_clr_valid_i(mw_clr_valid), .mw_clr_dirty_i(mw_clr_dirty),
    .a_idx_i({cur_set, cur_way}),
    .a_valid_o(cur_valid), .a_dirty_o(cur_dirty), .a_lock_o(cur_lock),
    .a_ns_o(cur_ns), .a_asid_o(cur_asid), .a_tag_o(cur_tag),
    .b_idx_i({rd_set_i, rd_way_i}),
    .b_valid_o(rd_valid_o), .b_dirty_o(rd_dirty_o), .b_lock_o(rd_lock_o), .b_ns_o(rd_ns_o)
  );

  cme_select #(.ASID_W(ASID_W), .TAG_W(TAG_W)) u_sel (
    .line_valid_i(cur_valid), .line_ns_i(cur_ns),
    .line_asid_i(cur_asid), .line_tag_i(cur_tag),
    .scope_i(scope_q), .sec_i(sec_q), .asid_i(asid_q), .ns_i(ns_q), .tag_i(tag_q),
    .hit_o(hit)
  );

  cme_ctrl #(
    .N_SETS(N_SETS), .N_WAYS(N_WAYS), .ASID_W(ASID_W), .VA_W(VA_W),
    .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_vld_i, .cmd_rdy_o, .cmd_op_i, .cmd_scope_i, .cmd_sec_i,
    .cmd_asid_i, .cmd_ns_i, .cmd_va_i, .cmd_set_i, .cmd_way_i, .lock_abort_en_i,
    .hit_i(hit), .line_dirty_i(cur_dirty), .line_lock_i(cur_lock),
    .set_o(cur_set), .way_o(cur_way), .scope_o(scope_q), .sec_o(sec_q),
    .asid_o(asid_q), .ns_o(ns_q), .tag_o(tag_q), .abort_en_o(abort_en_q),
    .mw_en_o(mw_en), .mw_clr_valid_o(mw_clr_valid), .mw_clr_dirty_o(mw_clr_dirty),
    .busy_o, .done_o, .err_o, .wb_req_o, .wb_ack_i
  );

  assign wb_set_o = cur_set;
  assign wb_way_o = cur_way;
endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_vld_i,
  input logic             cmd_rdy_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             wb_req_o,
  input logic             wb_ack_i,
  input logic [SET_W-1:0] wb_set_o,
  input logic [WAY_W-1:0] wb_way_o,
  input logic             mw_en,
  input logic             mw_clr_valid,
  input logic             abort_en_q,
  input logic             cur_lock,
  input logic             cur_ns,
  input logic             sec_q,
  input logic [1:0]       scope_q
);
  p_refuse_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_rdy_o);

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i && cmd_rdy_o |=> busy_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_wb_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_set_o) && $stable(wb_way_o));

  p_wb_in_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> busy_o && !done_o);

  p_locked_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_en && abort_en_q |-> !cur_lock);

  // R2/R3: a non-secure walk or set/way never clears a secure-origin line
  p_ns_filter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_en && mw_clr_valid && !sec_q && scope_q != 2'd2 |-> cur_ns);
endmodule

bind cache_maint_engine cme_checker #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld_i), .cmd_rdy_o(cmd_rdy_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .wb_req_o(wb_req_o),
  .wb_ack_i(wb_ack_i), .wb_set_o(wb_set_o), .wb_way_o(wb_way_o),
  .mw_en(mw_en), .mw_clr_valid(mw_clr_valid), .abort_en_q(abort_en_q),
  .cur_lock(cur_lock), .cur_ns(cur_ns), .sec_q(sec_q), .scope_q(scope_q)
);

// File: tb/cache_maint_engine_bench.sv
`timescale 1ns/1ps
module cache_maint_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_vld = 0, cmd_rdy, cmd_sec = 0, cmd_ns = 0, abort_en = 0;
  logic [1:0]  cmd_op = 0, cmd_scope = 0;
  logic [7:0]  cmd_asid = 0;
  logic [31:0] cmd_va = 0;
  logic [3:0]  cmd_set = 0;
  logic [1:0]  cmd_way = 0;
  logic        busy, done, err, wb_req, wb_ack = 0;
  logic [3:0]  wb_set;
  logic [1:0]  wb_way;
  logic        f_we = 0, f_v = 0, f_d = 0, f_l = 0, f_ns = 0;
  logic [3:0]  f_set = 0;
  logic [1:0]  f_way = 0;
  logic [7:0]  f_asid = 0;
  logic [21:0] f_tag = 0;
  logic [3:0]  r_set = 0;
  logic [1:0]  r_way = 0;
  logic        r_v, r_d, r_l, r_ns;

  int total = 0, bad = 0;
  int cyc, wbn, hold_bad, got_err;

  cache_maint_engine u_cache_maint_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_vld_i(cmd_vld), .cmd_rdy_o(cmd_rdy), .cmd_op_i(cmd_op), .cmd_scope_i(cmd_scope),
    .cmd_sec_i(cmd_sec), .cmd_asid_i(cmd_asid), .cmd_ns_i(cmd_ns), .cmd_va_i(cmd_va),
    .cmd_set_i(cmd_set), .cmd_way_i(cmd_way), .lock_abort_en_i(abort_en),
    .busy_o(busy), .done_o(done), .err_o(err), .wb_req_o(wb_req), .wb_ack_i(wb_ack),
    .wb_set_o(wb_set), .wb_way_o(wb_way),
    .fill_we_i(f_we), .fill_set_i(f_set), .fill_way_i(f_way), .fill_valid_i(f_v),
    .fill_dirty_i(f_d), .fill_lock_i(f_l), .fill_ns_i(f_ns), .fill_asid_i(f_asid),
    .fill_tag_i(f_tag), .rd_set_i(r_set), .rd_way_i(r_way),
    .rd_valid_o(r_v), .rd_dirty_o(r_d), .rd_lock_o(r_l), .rd_ns_o(r_ns)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int s, input int w, input logic v, d, l, ns,
                      input logic [7:0] asid, input logic [21:0] tag);
    @(negedge clk);
    f_set = 4'(s); f_way = 2'(w); f_v = v; f_d = d; f_l = l; f_ns = ns;
    f_asid = asid; f_tag = tag; f_we = 1'b1;
    @(negedge clk);
    f_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) fill(i / 4, i % 4, 0, 0, 0, 0, 8'h0, 22'h0);
  endtask

  // returns {valid, dirty}
  task automatic rd(input int s, input int w, output logic v, output logic d);
    @(negedge clk);
    r_set = 4'(s); r_way = 2'(w);
    #1;
    v = r_v; d = r_d;
  endtask

  function automatic logic [31:0] mkva(input logic [21:0] tag, input int s);
    return {tag, 4'(s), 6'h15};
  endfunction

  task automatic issue(input logic [1:0] op, sc, input logic sec, input logic [7:0] asid,
                       input logic ns, input logic [31:0] va, input int s, input int w,
                       input int ack_dly);
    int req_run;
    logic [3:0] s0;
    logic [1:0] w0;
    @(negedge clk);
    cmd_op = op; cmd_scope = sc; cmd_sec = sec; cmd_asid = asid; cmd_ns = ns;
    cmd_va = va; cmd_set = 4'(s); cmd_way = 2'(w); cmd_vld = 1'b1;
    @(negedge clk);
    cmd_vld = 1'b0;
    cyc = 1; wbn = 0; hold_bad = 0; req_run = 0; s0 = 0; w0 = 0;
    while (!done && cyc < 1000) begin
      if (wb_req) begin
        if (req_run == 0) begin wbn++; s0 = wb_set; w0 = wb_way; end
        else if (wb_set != s0 || wb_way != w0) hold_bad++;
        req_run++;
        wb_ack = (req_run > ack_dly);
      end else begin
        req_run = 0;
        wb_ack = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R11 done reached", int'(done), 1);
    got_err = int'(err);
    wb_ack = 1'b0;
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
    chk("R11 err only with done", int'(err), 0);
  endtask

  task automatic t_reset();
    logic v, d;
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R10 reset rdy", int'(cmd_rdy), 1);
    chk("R6 reset wb_req", int'(wb_req), 0);
    rd(3, 1, v, d);
    chk("R1 reset line invalid", int'(v), 0);
  endtask

  task automatic t_inv_all_sec();
    logic v, d;
    clear_all();
    abort_en = 0;
    fill(0, 0, 1, 0, 0, 0, 8'h1, 22'h11);
    fill(3, 2, 1, 1, 0, 1, 8'h2, 22'h22);
    fill(15, 3, 1, 0, 0, 0, 8'h3, 22'h33);
    issue(2'd0, 2'd0, 1'b1, 8'h0, 1'b0, 32'h0, 0, 0, 0);
    chk("R1 walk length", cyc, 65);
    chk("R1 no error", got_err, 0);
    chk("R7 invalidate no writeback", wbn, 0);
    rd(0, 0, v, d);  chk("R1 s0w0 invalid", int'(v), 0);
    rd(3, 2, v, d);  chk("R1 s3w2 invalid", int'(v), 0);
    chk("R7 dirty dropped", int'(d), 0);
    rd(15, 3, v, d); chk("R1 last line invalid", int'(v), 0);
  endtask

  task automatic t_inv_all_ns();
    logic v, d;
    clear_all();
    abort_en = 1;
    fill(1, 1, 1, 0, 0, 0, 8'h1, 22'h1);
    fill(2, 0, 1, 0, 0, 1, 8'h1, 22'h2);
    fill(4, 3, 1, 0, 1, 0, 8'h1, 22'h3);
    issue(2'd0, 2'd0, 1'b0, 8'h0, 1'b0, 32'h0, 0, 0, 0);
    chk("R9 unselected lock no abort", got_err, 0);
    rd(1, 1, v, d); chk("R2 secure line kept", int'(v), 1);
    rd(2, 0, v, d); chk("R2 ns line invalidated", int'(v), 0);
    rd(4, 3, v, d); chk("R2 locked secure line kept", int'(v), 1);
    abort_en = 0;
  endtask

  task automatic t_setway();
    logic v, d;
    clear_all();
    fill(5, 1, 1, 0, 0, 0, 8'h1, 22'h5);
    fill(6, 2, 1, 0, 0, 1, 8'h1, 22'h6);
    issue(2'd0, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 5, 1, 0);
    chk("R3 ns on secure line no error", got_err, 0);
    rd(5, 1, v, d); chk("R3 secure line untouched", int'(v), 1);
    issue(2'd0, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 6, 2, 0);
    rd(6, 2, v, d); chk("R3 ns on ns line invalidated", int'(v), 0);
    issue(2'd0, 2'd1, 1'b1, 8'h0, 1'b0, 32'h0, 5, 1, 0);
    rd(5, 1, v, d); chk("R4 secure set/way invalidates", int'(v), 0);
  endtask

  task automatic t_va();
    logic v, d;
    clear_all();
    fill(7, 0, 1, 0, 0, 1, 8'h3, 22'h0ABCD);
    fill(7, 1, 1, 0, 0, 1, 8'h4, 22'h0ABCD);
    fill(7, 2, 1, 0, 0, 0, 8'h3, 22'h0ABCD);
    fill(7, 3, 1, 0, 0, 1, 8'h3, 22'h01234);
    issue(2'd0, 2'd2, 1'b0, 8'h3, 1'b1, mkva(22'h0ABCD, 7), 0, 0, 0);
    rd(7, 0, v, d); chk("R5 full match invalidated", int'(v), 0);
    rd(7, 1, v, d); chk("R5 asid mismatch kept", int'(v), 1);
    rd(7, 2, v, d); chk("R5 ns mismatch kept", int'(v), 1);
    rd(7, 3, v, d); chk("R5 tag mismatch kept", int'(v), 1);
    issue(2'd0, 2'd2, 1'b1, 8'h3, 1'b0, mkva(22'h0ABCD, 7), 0, 0, 0);
    rd(7, 2, v, d); chk("R5 secure requester ns0 space", int'(v), 0);
    rd(7, 1, v, d); chk("R5 asid mismatch still kept", int'(v), 1);
  endtask

  task automatic t_clean();
    logic v, d;
    clear_all();
    fill(8, 0, 1, 1, 0, 1, 8'h1, 22'h8);
    fill(8, 1, 1, 0, 0, 1, 8'h1, 22'h9);
    issue(2'd1, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 8, 0, 3);
    chk("R6 one writeback", wbn, 1);
    chk("R6 request held stable", hold_bad, 0);
    rd(8, 0, v, d);
    chk("R6 clean keeps valid", int'(v), 1);
    chk("R6 clean clears dirty", int'(d), 0);
    issue(2'd1, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 8, 1, 0);
    chk("R6 clean line no writeback", wbn, 0);
  endtask

  task automatic t_cinv();
    logic v, d;
    clear_all();
    fill(9, 3, 1, 1, 0, 0, 8'h1, 22'h9);
    issue(2'd2, 2'd1, 1'b1, 8'h0, 1'b0, 32'h0, 9, 3, 1);
    chk("R7 clean-inv writeback", wbn, 1);
    rd(9, 3, v, d);
    chk("R7 clean-inv clears valid", int'(v), 0);
    chk("R7 clean-inv clears dirty", int'(d), 0);
  endtask

  task automatic t_abort();
    logic v, d;
    clear_all();
    abort_en = 1;
    fill(10, 0, 1, 0, 1, 1, 8'h1, 22'hA);
    issue(2'd0, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 10, 0, 0);
    chk("R8 ns set/way locked aborts", got_err, 1);
    rd(10, 0, v, d); chk("R8 locked line unchanged", int'(v), 1);
    fill(0, 1, 1, 0, 0, 0, 8'h1, 22'h1);
    fill(2, 2, 1, 0, 1, 0, 8'h1, 22'h2);
    fill(12, 0, 1, 0, 0, 0, 8'h1, 22'h3);
    issue(2'd0, 2'd0, 1'b1, 8'h0, 1'b0, 32'h0, 0, 0, 0);
    chk("R8 secure walk aborts", got_err, 1);
    rd(0, 1, v, d);  chk("R8 earlier line stays invalidated", int'(v), 0);
    rd(2, 2, v, d);  chk("R8 locked line kept", int'(v), 1);
    rd(12, 0, v, d); chk("R8 later line untouched", int'(v), 1);
    fill(11, 1, 1, 1, 1, 1, 8'h7, 22'h0BEEF);
    issue(2'd1, 2'd2, 1'b0, 8'h7, 1'b1, mkva(22'h0BEEF, 11), 0, 0, 0);
    chk("R8 va clean aborts", got_err, 1);
    chk("R8 no writeback on abort", wbn, 0);
    rd(11, 1, v, d); chk("R8 dirty kept", int'(d), 1);
    abort_en = 0;
  endtask

  task automatic t_abort_off();
    logic v, d;
    clear_all();
    abort_en = 0;
    fill(10, 0, 1, 0, 1, 1, 8'h1, 22'hA);
    issue(2'd0, 2'd1, 1'b0, 8'h0, 1'b0, 32'h0, 10, 0, 0);
    chk("R9 abort off no error", got_err, 0);
    rd(10, 0, v, d); chk("R9 locked line maintained", int'(v), 0);
  endtask

  task automatic t_busy();
    logic v, d;
    int rdy_seen;
    clear_all();
    fill(13, 2, 1, 0, 0, 0, 8'h1, 22'hD);
    @(negedge clk);
    cmd_op = 2'd0; cmd_scope = 2'd0; cmd_sec = 1'b0; cmd_vld = 1'b1;
    @(negedge clk);
    rdy_seen = 0;
    cmd_scope = 2'd1; cmd_sec = 1'b1; cmd_set = 4'd13; cmd_way = 2'd2;
    for (int k = 0; k < 4; k++) begin
      if (cmd_rdy) rdy_seen++;
      @(negedge clk);
    end
    cmd_vld = 1'b0;
    chk("R10 not ready while busy", rdy_seen, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle afterwards", int'(busy), 0);
    rd(13, 2, v, d); chk("R10 refused command had no effect", int'(v), 1);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inv_all_sec();
    t_inv_all_ns();
    t_setway();
    t_va();
    t_clean();
    t_cinv();
    t_abort();
    t_abort_off();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule